// File: doc/BRIEF.md
# Reference Divider with Selectable Phase Taps

This block divides an incoming reference clock in two stages. A programmable prescaler first divides by a ratio between 4 and 1023. A 3-bit binary counter then advances once each time the prescaler wraps. The even values of that counter (0, 2, 4 and 6) give four evenly spaced timing taps. Two independent 2-bit selects pick one tap for the main phase detector and one for the auxiliary phase detector. Each detector gets a one-clock-wide strobe once every 8·N reference cycles.

The two loops can sit on different taps. Their comparison instants are then spread apart inside the 8·N cycle frame, which keeps the two loops from disturbing each other. The divider runs while either loop is powered. When both loops are off it halts and clears all of its counting state, so the tap phases after a restart do not depend on history.

Top module: `refdiv_top`

## Requirements
- R1: The effective ratio Neff is max(NREF, 4). Once running, each selected output pulses exactly once in every 8·Neff reference cycles.
- R2: The 3-bit counter steps by one on each prescaler wrap, wrapping from 7 to 0. Each step takes Neff cycles.
- R3: The main strobe fires in the cycle in which the 3-bit counter enters value 2·RSM. Counting enabled clock edges from the first edge at which the divider runs, the first main strobe is visible after edge 2·RSM·Neff, or after edge 8·Neff when RSM is 0.
- R4: The auxiliary strobe follows the same rule with RSA in place of RSM, independently of RSM.
- R5: The divider runs when pd1 OR pd2 is 1. With both at 0, both strobes stay low and all counters return to zero. A restart therefore repeats the R3/R4 timing exactly.
- R6: Every strobe is exactly one reference cycle wide.
- R7: An NREF value below 4 (including 0) divides as if it were 4.
- R8: During and immediately after reset, both strobes are low.
- R9: With equal selects the two strobes coincide. Otherwise the auxiliary strobe trails the main strobe by ((2·RSA − 2·RSM) mod 8)·Neff cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| nref_i | input | 10 | Prescaler ratio; values below 4 are clamped to 4 |
| rsm_i | input | 2 | Tap select for the main detector strobe |
| rsa_i | input | 2 | Tap select for the auxiliary detector strobe |
| pd1_i | input | 1 | Main loop power enable (1 = on) |
| pd2_i | input | 1 | Auxiliary loop power enable (1 = on) |
| main_ref_o | output | 1 | One-cycle main reference strobe |
| aux_ref_o | output | 1 | One-cycle auxiliary reference strobe |

## Verification
The two tap decoders can fire in the same cycle. This happens when RSM and RSA are equal, because both decode the same counter transition. The bench provokes it by running both selects at 2 with a ratio of 7. It then checks that both strobes rise after the same enabled edge and that each is still a single cycle wide. With distinct selects, the bench judges the measured main-to-auxiliary spacing against the modular tap distance times Neff.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
  localparam int unsigned OCT_W = 3;
  localparam int unsigned SEL_W = 2;
  localparam int unsigned N_TAPS = 1 << SEL_W;

  function automatic int unsigned eff_ratio(input int unsigned n, input int unsigned floor_v);
    return (n < floor_v) ? floor_v : n;
  endfunction

  function automatic logic [OCT_W-1:0] tap_value(input logic [SEL_W-1:0] sel);
    return OCT_W'(32'(sel) << (OCT_W - SEL_W));
  endfunction
endpackage

// File: rtl/refdiv_prescale.sv
module refdiv_prescale #(
  parameter int unsigned NREF_W   = 10,
  parameter int unsigned NREF_MIN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [NREF_W-1:0] nref,
  output logic              tick,
  output logic [NREF_W-1:0] cnt
);
  import refdiv_pkg::*;

  logic [NREF_W-1:0] last_val;

  // last count value of one prescaler period
  assign last_val = NREF_W'(eff_ratio(32'(nref), NREF_MIN) - 1);
  // >= guards against a ratio lowered below the current count
  assign tick     = run && (cnt >= last_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!run)    cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/refdiv_octal.sv
module refdiv_octal (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        run,
  input  logic                        tick,
  output logic [refdiv_pkg::OCT_W-1:0] val,
  output logic [refdiv_pkg::OCT_W-1:0] nxt
);
  assign nxt = val + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     val <= '0;
    else if (!run)  val <= '0;
    else if (tick)  val <= nxt;
  end
endmodule

// File: rtl/refdiv_tap.sv
module refdiv_tap (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         run,
  input  logic                         tick,
  input  logic [refdiv_pkg::OCT_W-1:0] nxt,
  input  logic [refdiv_pkg::SEL_W-1:0] sel,
  output logic                         pulse
);
  import refdiv_pkg::*;

  logic hit;
  // fire on the step that moves the counter onto the selected tap
  assign hit = run && tick && (nxt == tap_value(sel));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse <= 1'b0;
    else        pulse <= hit;
  end
endmodule

// File: rtl/refdiv_top.sv
module refdiv_top #(
  parameter int unsigned NREF_W   = 10,
  parameter int unsigned NREF_MIN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NREF_W-1:0] nref_i,
  input  logic [1:0]        rsm_i,
  input  logic [1:0]        rsa_i,
  input  logic              pd1_i,
  input  logic              pd2_i,
  output logic              main_ref_o,
  output logic              aux_ref_o
);
  import refdiv_pkg::*;

  localparam int unsigned N_DET = 2;

  logic              run;
  logic              pre_tick;
  logic [NREF_W-1:0] pre_cnt;
  logic [OCT_W-1:0]  oct_val;
  logic [OCT_W-1:0]  oct_next;
  logic [SEL_W-1:0]  sel_vec [N_DET];
  logic [N_DET-1:0]  pulse_vec;

  assign run = pd1_i | pd2_i;
  assign sel_vec[0] = rsm_i;
  assign sel_vec[1] = rsa_i;

  refdiv_prescale #(.NREF_W(NREF_W), .NREF_MIN(NREF_MIN)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .nref(nref_i),
    .tick(pre_tick), .cnt(pre_cnt)
  );

  refdiv_octal u_oct (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(pre_tick),
    .val(oct_val), .nxt(oct_next)
  );

  for (genvar d = 0; d < N_DET; d++) begin : g_det
    refdiv_tap u_tap (
      .clk(clk), .rst_n(rst_n), .run(run), .tick(pre_tick),
      .nxt(oct_next), .sel(sel_vec[d]), .pulse(pulse_vec[d])
    );
  end

  assign main_ref_o = pulse_vec[0];
  assign aux_ref_o  = pulse_vec[1];
endmodule

// File: rtl/refdiv_chk.sv
module refdiv_chk #(
  parameter int unsigned NREF_W = 10
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         run,
  input logic                         pre_tick,
  input logic [NREF_W-1:0]            pre_cnt,
  input logic [refdiv_pkg::OCT_W-1:0] oct_val,
  input logic [1:0]                   rsm,
  input logic [1:0]                   rsa,
  input logic                         main_p,
  input logic                         aux_p
);
  import refdiv_pkg::*;

  a_r1_pre_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    pre_tick |=> pre_cnt == '0);

  a_r2_oct_step: assert property (@(posedge clk) disable iff (!rst_n)
    pre_tick |=> oct_val == OCT_W'($past(oct_val) + 1'b1));

  a_r3_main_tap: assert property (@(posedge clk) disable iff (!rst_n)
    main_p |-> oct_val == tap_value($past(rsm)));

  a_r4_aux_tap: assert property (@(posedge clk) disable iff (!rst_n)
    aux_p |-> oct_val == tap_value($past(rsa)));

  a_r5_stop_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!main_p && !aux_p && oct_val == '0 && pre_cnt == '0));

  a_r6_main_width: assert property (@(posedge clk) disable iff (!rst_n)
    main_p |=> !main_p);

  a_r6_aux_width: assert property (@(posedge clk) disable iff (!rst_n)
    aux_p |=> !aux_p);
endmodule

bind refdiv_top refdiv_chk #(.NREF_W(NREF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .pre_tick(pre_tick),
  .pre_cnt(pre_cnt), .oct_val(oct_val), .rsm(rsm_i), .rsa(rsa_i),
  .main_p(main_ref_o), .aux_p(aux_ref_o)
);

// File: tb/sim_refdiv_top.sv
module sim_refdiv_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] nref = 10'd5;
  logic [1:0] rsm = '0, rsa = '0;
  logic       pd1 = 1'b0, pd2 = 1'b0;
  logic       main_p, aux_p;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  refdiv_top u0 (
    .clk(clk), .rst_n(rst_n), .nref_i(nref), .rsm_i(rsm), .rsa_i(rsa),
    .pd1_i(pd1), .pd2_i(pd2), .main_ref_o(main_p), .aux_ref_o(aux_p)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ratio_of(input int n);
    return (n < 4) ? 4 : n;
  endfunction

  function automatic int first_at(input int sel, input int ne);
    return ((sel == 0) ? 8 : 2 * sel) * ne;
  endfunction

  task automatic test_reset();
    @(negedge clk);
    chk(!main_p && !aux_p, "R8 low in reset", {main_p, aux_p}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!main_p && !aux_p, "R8 low after reset", {main_p, aux_p}, 0);
  endtask

  // Enables the divider, runs 16*Neff+2 edges, measures both strobes.
  task automatic run_case(input int n, input int sm, input int sa,
                          input bit p1, input bit p2, input string tag);
    int ne, len, fm, fa, cm, ca, wm, wa;
    bit pm, pa;
    ne = ratio_of(n);
    len = 16 * ne + 2;
    fm = -1; fa = -1; cm = 0; ca = 0; wm = 0; wa = 0; pm = 0; pa = 0;
    @(negedge clk);
    pd1 = 1'b0; pd2 = 1'b0;
    nref = 10'(n); rsm = 2'(sm); rsa = 2'(sa);
    repeat (3) @(negedge clk);
    pd1 = p1; pd2 = p2;
    for (int j = 1; j <= len; j++) begin
      @(negedge clk);
      if (main_p) begin cm++; if (fm < 0) fm = j; if (pm) wm++; end
      if (aux_p)  begin ca++; if (fa < 0) fa = j; if (pa) wa++; end
      pm = main_p; pa = aux_p;
    end
    chk(fm == first_at(sm, ne), {"R3 first main ", tag}, fm, first_at(sm, ne));
    chk(fa == first_at(sa, ne), {"R4 first aux ", tag}, fa, first_at(sa, ne));
    chk(cm == 2, {"R1 main count per 16N ", tag}, cm, 2);
    chk(ca == 2, {"R1 aux count per 16N ", tag}, ca, 2);
    chk(wm == 0 && wa == 0, {"R6 single-cycle width ", tag}, wm + wa, 0);
    chk(((fa - fm) % (8 * ne) + 8 * ne) % (8 * ne) == (((2 * sa - 2 * sm) % 8 + 8) % 8) * ne,
        {"R9 main-aux spacing ", tag}, fa - fm, (((2 * sa - 2 * sm) % 8 + 8) % 8) * ne);
  endtask

  task automatic test_stop_restart();
    int seen, f;
    @(negedge clk);
    pd1 = 1'b0; pd2 = 1'b0; nref = 10'd6; rsm = 2'd1; rsa = 2'd3;
    repeat (2) @(negedge clk);
    pd1 = 1'b1;
    repeat (20) @(negedge clk);
    pd1 = 1'b0;
    seen = 0;
    for (int j = 0; j < 120; j++) begin
      @(negedge clk);
      if (main_p || aux_p) seen++;
    end
    chk(seen == 0, "R5 quiet while stopped", seen, 0);
    pd2 = 1'b1;
    f = -1;
    for (int j = 1; j <= 60; j++) begin
      @(negedge clk);
      if (main_p && f < 0) f = j;
    end
    chk(f == 12, "R5 restart phase deterministic", f, 12);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    test_reset();
    run_case(5, 0, 2, 1, 0, "n5");
    run_case(2, 1, 3, 0, 1, "R7 clamp n2");
    run_case(0, 3, 0, 1, 1, "R7 clamp n0");
    run_case(7, 2, 2, 1, 0, "R9 equal selects");
    run_case(100, 3, 1, 0, 1, "n100");
    test_stop_restart();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule